// File: doc/BRIEF.md
# Secured Cache Auxiliary Control Register

This block holds the 32-bit auxiliary configuration word of a level-two cache and guards every access to it by security state and privilege. An access is presented for one cycle with a valid strobe, a read/write flag, a secure flag, a privileged flag and write data.

- A secure privileged access may read or write the word.
- A non-secure privileged access may only read it.
- Anything else raises a one-cycle undefined-access fault and changes nothing.

Read data returns in the same cycle as the access. A permitted write takes effect on the next rising clock edge.

The configuration fields are brought out as separate control outputs for the cache datapath. These are:

- the read-multiplexer timing;
- the ECC or parity choice;
- several write and forwarding disables;
- the cacheability view;
- the tag and data RAM latencies, each decoded into a cycle count.

A build parameter states whether parity/ECC storage exists. Without it, the protection-enable bit is held at 0. Software can therefore probe for the feature by setting that bit and reading it back.

Top module: `cacheaux_top`

## Requirements
- R1: A read with accValid=1, accWrite=0, accPriv=1 and accSecure=1 returns the current word on rdData in the same cycle, with undefFault=0.
- R2: A write with accValid=1, accWrite=1, accSecure=1 and accPriv=1 stores accWdata, masked to the writable bits, at the next rising edge.
- R3: A non-secure privileged read behaves like R1. A non-secure privileged write raises undefFault and leaves the word unchanged.
- R4: Any access with accPriv=0 raises undefFault, returns rdData=0 and leaves the word unchanged.
- R5: undefFault is high only in a cycle where accValid=1 and the access is forbidden. rdData is 0 in every cycle without a permitted read.
- R6: A synchronous reset (rst=1) clears the whole word. All single-bit controls then read 0, and both latencies read 2 cycles.
- R7: Bit 21 (protection enable) is writable only when HAS_PROT_RAM=1. With HAS_PROT_RAM=0 it reads 0 whatever is written.
- R8: Only bits 29, 28, 27, 25, 24, 23, 22, 21, 16, 8:6 and 3:0 are writable (mask 0x3BE101CF). All other bits ignore writes and read 0.
- R9: tagLatency decodes bits 8:6: 0 or 1 gives 2, 2 gives 3, 3 to 7 give 4.
- R10: dataLatency decodes bits 3:0: 0 or 1 gives 2, n from 2 to 12 gives n+1, 13 to 15 give 13.
- R11: Single-bit outputs follow their word bits, as listed below.

| Output | Word bit |
|---|---|
| readMuxOneCycle | 29 |
| eccSelect | 28 |
| loadFwdDisable | 27 |
| writeCombineDisable | 25 |
| allocDelayDisable | 24 |
| allocCombineDisable | 23 |
| writeAllocDisable | 22 |
| protEnable | 21 |
| innerCacheability | 16 |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| accValid | input | 1 | An access is presented this cycle |
| accWrite | input | 1 | 1 = write, 0 = read |
| accSecure | input | 1 | 1 = secure state |
| accPriv | input | 1 | 1 = privileged mode |
| accWdata | input | 32 | Write data |
| rdData | output | 32 | Read data, 0 unless a permitted read |
| undefFault | output | 1 | Undefined-access fault pulse |
| readMuxOneCycle | output | 1 | 1 = one-cycle read mux select, 0 = two cycles |
| eccSelect | output | 1 | 1 = ECC, 0 = parity |
| loadFwdDisable | output | 1 | Disables load data forwarding |
| writeCombineDisable | output | 1 | Disables write combining |
| allocDelayDisable | output | 1 | Disables the delayed full-line write allocate |
| allocCombineDisable | output | 1 | Disables combining in write buffers |
| writeAllocDisable | output | 1 | Disables allocate on write miss |
| protEnable | output | 1 | Enables parity/ECC checking |
| innerCacheability | output | 1 | 1 = inner attributes, 0 = outer |
| tagLatency | output | 3 | Tag RAM latency in cycles |
| dataLatency | output | 4 | Data RAM latency in cycles |

## Verification
The following are checked on every cycle:

- the permission rules and the fault raised by forbidden accesses;
- that a fault never alters the stored word;
- that a permitted write lands masked;
- that reserved bits read 0;
- the tied-off protection bit;
- the legal range of both latency outputs.

Only the bench scenarios show the rest. These are the exact decode of every latency code, each control output following its own bit, the feature probe answered differently by the two builds, and a reset taken in the middle of operation.

// File: rtl/cacheaux_pkg.sv
package cacheaux_pkg;
  localparam int WORD_W = 32;

  localparam int BIT_RDMUX     = 29;
  localparam int BIT_ECCSEL    = 28;
  localparam int BIT_LDFWD_DIS = 27;
  localparam int BIT_WCOMB_DIS = 25;
  localparam int BIT_WADLY_DIS = 24;
  localparam int BIT_WACMB_DIS = 23;
  localparam int BIT_WALLOC_DIS= 22;
  localparam int BIT_PROT_EN   = 21;
  localparam int BIT_INNER     = 16;

  localparam int TAG_LSB   = 6;
  localparam int TAG_W     = 3;
  localparam int TAG_MAX   = 4;
  localparam int DATA_LSB  = 0;
  localparam int DATA_W    = 4;
  localparam int DATA_MAX  = 13;
  localparam int TAG_OW    = $clog2(TAG_MAX + 1);
  localparam int DATA_OW   = $clog2(DATA_MAX + 1);

  typedef struct packed {
    logic rdEn;
    logic wrEn;
    logic fault;
  } accStrobes_t;

  function automatic logic [WORD_W-1:0] writableMask(input bit hasProt);
    logic [WORD_W-1:0] m;
    m = '0;
    m[BIT_RDMUX]      = 1'b1;
    m[BIT_ECCSEL]     = 1'b1;
    m[BIT_LDFWD_DIS]  = 1'b1;
    m[BIT_WCOMB_DIS]  = 1'b1;
    m[BIT_WADLY_DIS]  = 1'b1;
    m[BIT_WACMB_DIS]  = 1'b1;
    m[BIT_WALLOC_DIS] = 1'b1;
    m[BIT_PROT_EN]    = hasProt;
    m[BIT_INNER]      = 1'b1;
    m[TAG_LSB +: TAG_W]   = '1;
    m[DATA_LSB +: DATA_W] = '1;
    return m;
  endfunction
endpackage

// File: rtl/cacheaux_access_ctrl.sv
module cacheaux_access_ctrl
  import cacheaux_pkg::*;
(
  input  logic        accValid,
  input  logic        accWrite,
  input  logic        accSecure,
  input  logic        accPriv,
  output accStrobes_t strobes
);
  logic readOk;
  logic writeOk;

  always_comb begin
    readOk        = accValid && !accWrite && accPriv;
    writeOk       = accValid && accWrite && accPriv && accSecure;
    strobes.rdEn  = readOk;
    strobes.wrEn  = writeOk;
    strobes.fault = accValid && !(readOk || writeOk);
  end
endmodule

// File: rtl/cacheaux_lat_decode.sv
module cacheaux_lat_decode #(
  parameter int IN_W  = 4,
  parameter int CAP   = 13,
  parameter int OUT_W = $clog2(CAP + 1)
) (
  input  logic [IN_W-1:0]  field,
  output logic [OUT_W-1:0] cycles
);
  int value;

  always_comb begin
    value = (field == '0) ? 2 : int'(field) + 1;
    if (value > CAP) value = CAP;
    cycles = OUT_W'(value);
  end
endmodule

// File: rtl/cacheaux_datapath.sv
module cacheaux_datapath
  import cacheaux_pkg::*;
#(
  parameter bit HAS_PROT_RAM = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  accStrobes_t        strobes,
  input  logic [WORD_W-1:0]  wrData,
  output logic [WORD_W-1:0]  rdData,
  output logic [WORD_W-1:0]  cfgWordOut,
  output logic [TAG_OW-1:0]  tagCycles,
  output logic [DATA_OW-1:0] dataCycles
);
  localparam logic [WORD_W-1:0] WR_MASK = writableMask(HAS_PROT_RAM);

  logic [WORD_W-1:0] cfgWord;

  always_ff @(posedge clk) begin
    if (rst)               cfgWord <= '0;
    else if (strobes.wrEn) cfgWord <= wrData & WR_MASK;
  end

  assign rdData     = strobes.rdEn ? cfgWord : '0;
  assign cfgWordOut = cfgWord;

  cacheaux_lat_decode #(.IN_W(TAG_W), .CAP(TAG_MAX), .OUT_W(TAG_OW)) u_tagDec (
    .field (cfgWord[TAG_LSB +: TAG_W]),
    .cycles(tagCycles)
  );

  cacheaux_lat_decode #(.IN_W(DATA_W), .CAP(DATA_MAX), .OUT_W(DATA_OW)) u_dataDec (
    .field (cfgWord[DATA_LSB +: DATA_W]),
    .cycles(dataCycles)
  );
endmodule

// File: rtl/cacheaux_top.sv
module cacheaux_top
  import cacheaux_pkg::*;
#(
  parameter bit HAS_PROT_RAM = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               accValid,
  input  logic               accWrite,
  input  logic               accSecure,
  input  logic               accPriv,
  input  logic [WORD_W-1:0]  accWdata,
  output logic [WORD_W-1:0]  rdData,
  output logic               undefFault,
  output logic               readMuxOneCycle,
  output logic               eccSelect,
  output logic               loadFwdDisable,
  output logic               writeCombineDisable,
  output logic               allocDelayDisable,
  output logic               allocCombineDisable,
  output logic               writeAllocDisable,
  output logic               protEnable,
  output logic               innerCacheability,
  output logic [TAG_OW-1:0]  tagLatency,
  output logic [DATA_OW-1:0] dataLatency
);
  accStrobes_t       strobes;
  logic [WORD_W-1:0] cfgWord;

  cacheaux_access_ctrl u_ctrl (
    .accValid (accValid),
    .accWrite (accWrite),
    .accSecure(accSecure),
    .accPriv  (accPriv),
    .strobes  (strobes)
  );

  cacheaux_datapath #(.HAS_PROT_RAM(HAS_PROT_RAM)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .wrData    (accWdata),
    .rdData    (rdData),
    .cfgWordOut(cfgWord),
    .tagCycles (tagLatency),
    .dataCycles(dataLatency)
  );

  assign undefFault          = strobes.fault;
  assign readMuxOneCycle     = cfgWord[BIT_RDMUX];
  assign eccSelect           = cfgWord[BIT_ECCSEL];
  assign loadFwdDisable      = cfgWord[BIT_LDFWD_DIS];
  assign writeCombineDisable = cfgWord[BIT_WCOMB_DIS];
  assign allocDelayDisable   = cfgWord[BIT_WADLY_DIS];
  assign allocCombineDisable = cfgWord[BIT_WACMB_DIS];
  assign writeAllocDisable   = cfgWord[BIT_WALLOC_DIS];
  assign protEnable          = cfgWord[BIT_PROT_EN];
  assign innerCacheability   = cfgWord[BIT_INNER];
endmodule

// File: rtl/cacheaux_checker.sv
module cacheaux_checker
  import cacheaux_pkg::*;
#(
  parameter bit HAS_PROT_RAM = 1'b1
) (
  input logic               clk,
  input logic               rst,
  input logic               accValid,
  input logic               accWrite,
  input logic               accSecure,
  input logic               accPriv,
  input logic [WORD_W-1:0]  accWdata,
  input logic [WORD_W-1:0]  rdData,
  input logic               undefFault,
  input logic [WORD_W-1:0]  cfgWord,
  input logic               protEnable,
  input logic [TAG_OW-1:0]  tagLatency,
  input logic [DATA_OW-1:0] dataLatency
);
  localparam logic [WORD_W-1:0] MASK = writableMask(HAS_PROT_RAM);

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
    (accValid && accWrite && accSecure && accPriv) |=> (cfgWord == ($past(accWdata) & MASK)));

  assert_ns_write_fault_R3: assert property (@(posedge clk) disable iff (rst)
    (accValid && accWrite && !accSecure) |-> undefFault);

  assert_fault_keeps_word_R3: assert property (@(posedge clk) disable iff (rst)
    undefFault |=> $stable(cfgWord));

  assert_user_fault_R4: assert property (@(posedge clk) disable iff (rst)
    (accValid && !accPriv) |-> undefFault);

  assert_fault_rd_zero_R4: assert property (@(posedge clk) disable iff (rst)
    undefFault |-> (rdData == '0));

  assert_fault_needs_access_R5: assert property (@(posedge clk) disable iff (rst)
    undefFault |-> accValid);

  assert_prot_tied_R7: assert property (@(posedge clk) disable iff (rst)
    HAS_PROT_RAM || !protEnable);

  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (rdData & ~MASK) == '0);

  assert_tag_range_R9: assert property (@(posedge clk) disable iff (rst)
    (tagLatency >= TAG_OW'(2)) && (tagLatency <= TAG_OW'(TAG_MAX)));

  assert_data_range_R10: assert property (@(posedge clk) disable iff (rst)
    (dataLatency >= DATA_OW'(2)) && (dataLatency <= DATA_OW'(DATA_MAX)));
endmodule

bind cacheaux_top cacheaux_checker #(.HAS_PROT_RAM(HAS_PROT_RAM)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .accValid   (accValid),
  .accWrite   (accWrite),
  .accSecure  (accSecure),
  .accPriv    (accPriv),
  .accWdata   (accWdata),
  .rdData     (rdData),
  .undefFault (undefFault),
  .cfgWord    (cfgWord),
  .protEnable (protEnable),
  .tagLatency (tagLatency),
  .dataLatency(dataLatency)
);

// File: tb/cacheaux_top_tb.sv
module cacheaux_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        accValid = 1'b0, accWrite = 1'b0, accSecure = 1'b0, accPriv = 1'b0;
  logic [31:0] accWdata = '0;

  logic [31:0] rdA, rdB;
  logic        faultA, faultB;
  logic        muxA, eccA, ldfA, wcbA, wadA, wacA, walA, protA, innA;
  logic        muxB, eccB, ldfB, wcbB, wadB, wacB, walB, protB, innB;
  logic [2:0]  tagA, tagB;
  logic [3:0]  datA, datB;

  localparam logic [31:0] MASK_A = 32'h3BE1_01CF;
  localparam logic [31:0] MASK_B = 32'h3BC1_01CF;

  always #5 clk = ~clk;

  cacheaux_top #(.HAS_PROT_RAM(1'b1)) u_dut (
    .clk(clk), .rst(rst), .accValid(accValid), .accWrite(accWrite),
    .accSecure(accSecure), .accPriv(accPriv), .accWdata(accWdata),
    .rdData(rdA), .undefFault(faultA), .readMuxOneCycle(muxA), .eccSelect(eccA),
    .loadFwdDisable(ldfA), .writeCombineDisable(wcbA), .allocDelayDisable(wadA),
    .allocCombineDisable(wacA), .writeAllocDisable(walA), .protEnable(protA),
    .innerCacheability(innA), .tagLatency(tagA), .dataLatency(datA));

  cacheaux_top #(.HAS_PROT_RAM(1'b0)) u_dutNoProt (
    .clk(clk), .rst(rst), .accValid(accValid), .accWrite(accWrite),
    .accSecure(accSecure), .accPriv(accPriv), .accWdata(accWdata),
    .rdData(rdB), .undefFault(faultB), .readMuxOneCycle(muxB), .eccSelect(eccB),
    .loadFwdDisable(ldfB), .writeCombineDisable(wcbB), .allocDelayDisable(wadB),
    .allocCombineDisable(wacB), .writeAllocDisable(walB), .protEnable(protB),
    .innerCacheability(innB), .tagLatency(tagB), .dataLatency(datB));

  typedef struct {
    logic [31:0] rdExpA;
    logic [31:0] rdExpB;
    logic        faultExp;
    logic [31:0] wordA;
    logic [31:0] wordB;
    string       tag;
  } item_t;

  item_t       sbq[$];
  logic [31:0] modelA = '0, modelB = '0;
  int          nChecks = 0, nFails = 0;
  bit          done = 1'b0;

  function automatic int tagCyc(input logic [31:0] w);
    int f = int'(w[8:6]);
    if (f <= 1) return 2;
    if (f == 2) return 3;
    return 4;
  endfunction

  function automatic int dataCyc(input logic [31:0] w);
    int f = int'(w[3:0]);
    if (f <= 1) return 2;
    if (f >= 12) return 13;
    return f + 1;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  // Driver: one call presents one access (or an idle cycle) and queues the expectation.
  task automatic drive(input logic v, input logic w, input logic s, input logic p,
                       input logic [31:0] d, input string tag);
    item_t it;
    logic rdOk, wrOk;
    @(negedge clk);
    accValid = v; accWrite = w; accSecure = s; accPriv = p; accWdata = d;
    rdOk = v && !w && p;
    wrOk = v && w && p && s;
    it.rdExpA   = rdOk ? modelA : 32'h0;
    it.rdExpB   = rdOk ? modelB : 32'h0;
    it.faultExp = v && !(rdOk || wrOk);
    it.wordA    = modelA;
    it.wordB    = modelB;
    it.tag      = tag;
    sbq.push_back(it);
    if (wrOk) begin
      modelA = d & MASK_A;
      modelB = d & MASK_B;
    end
  endtask

  task automatic idle(input string tag);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 32'h0, tag);
  endtask

  task automatic spWrite(input logic [31:0] d, input string tag);
    drive(1'b1, 1'b1, 1'b1, 1'b1, d, tag);
  endtask

  task automatic spRead(input string tag);
    drive(1'b1, 1'b0, 1'b1, 1'b1, 32'h0, tag);
  endtask

  // Monitor: pops the item queued at this falling edge and compares.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sbq.size() != 0) begin
        item_t it;
        it = sbq.pop_front();
        chk(it.tag, "rdData", rdA, it.rdExpA);
        chk(it.tag, "rdData noProt", rdB, it.rdExpB);
        chk("R5", "undefFault", {31'b0, faultA}, {31'b0, it.faultExp});
        chk("R5", "undefFault noProt", {31'b0, faultB}, {31'b0, it.faultExp});
        chk("R11", "control bits",
            {23'b0, muxA, eccA, ldfA, wcbA, wadA, wacA, walA, protA, innA},
            {23'b0, it.wordA[29], it.wordA[28], it.wordA[27], it.wordA[25], it.wordA[24],
             it.wordA[23], it.wordA[22], it.wordA[21], it.wordA[16]});
        chk("R7", "protEnable noProt", {31'b0, protB}, {31'b0, it.wordB[21]});
        chk("R9", "tagLatency", {29'b0, tagA}, 32'(tagCyc(it.wordA)));
        chk("R10", "dataLatency", {28'b0, datA}, 32'(dataCyc(it.wordA)));
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual still running, expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle("R6");                         // reset state
    spRead("R1");
    spWrite(32'hFFFF_FFFF, "R2");       // R8 reserved bits masked off
    spRead("R8");
    drive(1'b1, 1'b0, 1'b0, 1'b1, 32'h0, "R3");          // non-secure privileged read
    drive(1'b1, 1'b1, 1'b0, 1'b1, 32'h0, "R3");          // non-secure privileged write faults
    spRead("R3");
    drive(1'b1, 1'b0, 1'b1, 1'b0, 32'h0, "R4");          // secure user read
    drive(1'b1, 1'b1, 1'b1, 1'b0, 32'h0, "R4");          // secure user write
    drive(1'b1, 1'b1, 1'b0, 1'b0, 32'h0, "R4");          // non-secure user write
    drive(1'b1, 1'b0, 1'b0, 1'b0, 32'h0, "R4");          // non-secure user read
    idle("R5");                                          // fault gone next cycle
    spRead("R4");
    spWrite(32'hC404_FE30, "R8");                        // reserved-only pattern
    spRead("R8");
    for (int t = 0; t < 8; t++) begin
      for (int d = 0; d < 16; d++) begin
        spWrite((32'(t) << 6) | 32'(d), "R2");
        spRead("R10");
      end
    end
    foreach (MASK_A[b]) begin
      if (MASK_A[b] && (b >= 16)) begin
        spWrite(32'h1 << b, "R11");
        spRead("R11");
      end
    end
    spWrite(32'h0020_0000, "R7");                        // feature probe
    spRead("R7");
    spWrite(32'h0000_0000, "R7");
    spRead("R7");
    spWrite(32'h3BE1_01CF, "R2");
    idle("R2");
    @(negedge clk);
    rst = 1'b1;
    modelA = '0;
    modelB = '0;
    @(negedge clk);
    rst = 1'b0;
    idle("R6");
    spRead("R6");
    repeat (4) idle("R5");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule